// File: doc/BRIEF.md
# Legacy Interrupt Vector Receiver

This block sits between a bank of level-sensitive legacy device interrupt lines and a processor that takes vectored interrupts. It translates each legacy line number into a fixed vector code through a sparse table. It serves one line at a time. While a line is being served, the block raises a level-5 request to the processor, sets a pending bit in its status byte, asserts a hard-interrupt request with a fixed trap code, and holds a three-word vector data record that software reads through a small select-and-read port.

Lines with no table entry are ignored. When several mapped lines are active together, the lowest-numbered one is served first. The block moves to another line only after the served line has gone low. That release costs one idle cycle, and the next line is taken on the edge after it.

Top module: `intr_vec_receiver`

## Requirements
- R1: After synchronous reset, the level-5 request, status byte, hard request, trap code, all three data words and the read port output are zero.
- R2: The vector code table maps line 1 to 0x29, line 4 to 0x2b, line 6 to 0x27, line 7 to 0x22 and line 12 to 0x2a.
- R3: On dispatch, data word 0 becomes 0x7C0 OR the vector code (bits 10:6 all ones, bits 5:0 the code, upper bits zero), and data words 1 and 2 become zero.
- R4: When the block is idle and a mapped line is high at a clock edge, the level-5 request, status bit 5 (mask 0x20) and the hard request all go high after that edge.
- R5: When the served line is low at a clock edge, the level-5 request, the status bit and the hard request all go low after that edge, and the data words keep their values.
- R6: Lines 0, 2, 3, 5, 8 to 11 and 13 to 15 never cause a dispatch.
- R7: Among several active mapped lines, the lowest-numbered one is dispatched. The next one is dispatched on the second edge after the served line goes low.
- R8: The trap code output is 0x60 while the hard request is high, and zero otherwise.
- R9: While the served line stays high, a newly active lower-numbered line neither preempts it nor alters the data words.
- R10: The read port returns data word 0, 1 or 2 for select 0, 1 or 2, and zero for select 3, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | Level-sensitive legacy interrupt lines, bit n is line n |
| rd_sel | input | 2 | Data word select for the read port |
| lvl5_req | output | 1 | Level-5 request to the processor |
| vec_status | output | 8 | Status byte; bit 5 set while a vector is pending |
| hard_req | output | 1 | Hard-interrupt request |
| trap_type | output | 9 | Trap code presented with the hard request |
| data_w0 | output | 64 | Vector data word 0 |
| data_w1 | output | 64 | Vector data word 1 |
| data_w2 | output | 64 | Vector data word 2 |
| rd_data | output | 64 | Selected data word |

## Verification
Each mapped line is driven on its own, which separates table errors from arbitration errors. A burst of only unmapped lines shows whether the mask leaks. Overlapping patterns with three lines high and then released one by one show whether the lowest line wins. They also show whether the idle gap between dispatches is present. Raising a lower line while a higher one is held tells a non-preemptive design apart from one that re-arbitrates every cycle. A behavioural model compared on every cycle catches any one-cycle slip in when the request rises or falls.

// File: rtl/ivr_pkg.sv
package ivr_pkg;

    localparam int CODE_W     = 6;
    localparam int ONES_W     = 5;
    localparam int ONES_SHIFT = 6;
    localparam int WORD0_W    = ONES_SHIFT + ONES_W;
    localparam int TRAP_W     = 9;
    localparam logic [TRAP_W-1:0] TRAP_CODE = 9'h060;
    localparam int STATUS_W   = 8;
    localparam int STATUS_BIT = 5;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic              hit;
        logic [CODE_W-1:0] code;
    } map_entry_t;

    // Sparse legacy-line to vector-code table.
    function automatic map_entry_t map_lookup(input int idx);
        map_entry_t e;
        e.hit  = 1'b1;
        e.code = '0;
        case (idx)
            1:       e.code = 6'h29;
            4:       e.code = 6'h2b;
            6:       e.code = 6'h27;
            7:       e.code = 6'h22;
            12:      e.code = 6'h2a;
            default: e.hit  = 1'b0;
        endcase
        return e;
    endfunction

    // First data word: all-ones field above the vector code.
    function automatic logic [WORD0_W-1:0] make_word0(input logic [CODE_W-1:0] code);
        logic [WORD0_W-1:0] w;
        w = '0;
        w[ONES_SHIFT +: ONES_W] = '1;
        w[CODE_W-1:0]           = code;
        return w;
    endfunction

endpackage

// File: rtl/ivr_line_map.sv
module ivr_line_map
    import ivr_pkg::*;
#(
    parameter int LINES = 16
) (
    input  logic [LINES-1:0]             lines,
    output logic [LINES-1:0]             req_mask,
    output logic [LINES-1:0][CODE_W-1:0] codes
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        localparam map_entry_t ENT = map_lookup(g);
        assign req_mask[g] = lines[g] & ENT.hit;
        assign codes[g]    = ENT.code;
    end

endmodule

// File: rtl/ivr_lowest_pick.sv
module ivr_lowest_pick #(
    parameter int N     = 16,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ivr_dispatch_regs.sv
module ivr_dispatch_regs
    import ivr_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int DATA_W = 64,
    parameter int IDX_W  = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [LINES-1:0]           lines,
    input  logic                       pick_any,
    input  logic [IDX_W-1:0]           pick_idx,
    input  logic [CODE_W-1:0]          pick_code,
    output logic                       busy,
    output logic [IDX_W-1:0]           cur_idx,
    output logic [2:0][DATA_W-1:0]     words
);

    rx_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cur_idx <= '0;
            words   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (pick_any) begin
                        state_q  <= ST_BUSY;
                        cur_idx  <= pick_idx;
                        words[0] <= DATA_W'(make_word0(pick_code));
                        words[1] <= '0;
                        words[2] <= '0;
                    end
                end
                ST_BUSY: begin
                    if (!lines[cur_idx]) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state_q == ST_BUSY);

endmodule

// File: rtl/intr_vec_receiver.sv
module intr_vec_receiver
    import ivr_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [LINES-1:0]    irq_lines,
    input  logic [1:0]          rd_sel,
    output logic                lvl5_req,
    output logic [STATUS_W-1:0] vec_status,
    output logic                hard_req,
    output logic [TRAP_W-1:0]   trap_type,
    output logic [DATA_W-1:0]   data_w0,
    output logic [DATA_W-1:0]   data_w1,
    output logic [DATA_W-1:0]   data_w2,
    output logic [DATA_W-1:0]   rd_data
);

    localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;

    logic [LINES-1:0]             req_mask;
    logic [LINES-1:0][CODE_W-1:0] codes;
    logic                         pick_any;
    logic [IDX_W-1:0]             pick_idx;
    logic                         busy;
    logic [IDX_W-1:0]             cur_idx;
    logic [2:0][DATA_W-1:0]       words;

    ivr_line_map #(.LINES(LINES)) u_map (
        .lines    (irq_lines),
        .req_mask (req_mask),
        .codes    (codes)
    );

    ivr_lowest_pick #(.N(LINES), .IDX_W(IDX_W)) u_pick (
        .req (req_mask),
        .any (pick_any),
        .idx (pick_idx)
    );

    ivr_dispatch_regs #(.LINES(LINES), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .lines     (irq_lines),
        .pick_any  (pick_any),
        .pick_idx  (pick_idx),
        .pick_code (codes[pick_idx]),
        .busy      (busy),
        .cur_idx   (cur_idx),
        .words     (words)
    );

    always_comb begin
        lvl5_req   = busy;
        hard_req   = busy;
        vec_status = '0;
        vec_status[STATUS_BIT] = busy;
        trap_type  = busy ? TRAP_CODE : '0;
        data_w0    = words[0];
        data_w1    = words[1];
        data_w2    = words[2];
        case (rd_sel)
            2'd0:    rd_data = words[0];
            2'd1:    rd_data = words[1];
            2'd2:    rd_data = words[2];
            default: rd_data = '0;
        endcase
    end

    // R4: a request only rises after a mapped line was seen high
    p_rise_src_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(hard_req) |-> ($past(req_mask) != '0));

    // R3: record format while a vector is pending
    p_word_fmt_r3: assert property (@(posedge clk) disable iff (rst)
        hard_req |-> (data_w1 == '0 && data_w2 == '0 &&
                      data_w0[ONES_SHIFT +: ONES_W] == '1));

    // R5: served line low drops every request flag on the next edge
    p_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (hard_req && !irq_lines[cur_idx]) |=>
            (!hard_req && !lvl5_req && vec_status == '0));

    // R9: no preemption while the served line is held
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (hard_req && irq_lines[cur_idx]) |=> (hard_req && $stable(data_w0)));

    // R6: only unmapped activity while idle never starts a dispatch
    p_unmapped_r6: assert property (@(posedge clk) disable iff (rst)
        (!hard_req && req_mask == '0) |=> !hard_req);

endmodule

// File: tb/intr_vec_receiver_bench.sv
`timescale 1ns/1ps
module intr_vec_receiver_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] irq_lines = '0;
    logic [1:0]  rd_sel = '0;
    logic        lvl5_req;
    logic [7:0]  vec_status;
    logic        hard_req;
    logic [8:0]  trap_type;
    logic [63:0] data_w0, data_w1, data_w2, rd_data;

    always #5 clk = ~clk;

    intr_vec_receiver u_intr_vec_receiver (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .rd_sel(rd_sel),
        .lvl5_req(lvl5_req), .vec_status(vec_status), .hard_req(hard_req),
        .trap_type(trap_type), .data_w0(data_w0), .data_w1(data_w1),
        .data_w2(data_w2), .rd_data(rd_data)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_en = 0;

    // Reference model state
    bit          m_busy = 0;
    int          m_cur = 0;
    logic [63:0] m_d0 = '0;

    function automatic int ref_code(input int i);
        case (i)
            1:  return 'h29;
            4:  return 'h2b;
            6:  return 'h27;
            7:  return 'h22;
            12: return 'h2a;
            default: return -1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy = 0; m_cur = 0; m_d0 = '0;
        end else if (m_busy) begin
            if (!irq_lines[m_cur]) m_busy = 0;
        end else begin
            for (int i = 0; i < 16; i++) begin
                if (irq_lines[i] && ref_code(i) >= 0) begin
                    m_busy = 1;
                    m_cur  = i;
                    m_d0   = 64'h7c0 | 64'(ref_code(i));
                    break;
                end
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #1;
        if (cmp_en) begin
            logic [63:0] exp_rd;
            case (rd_sel)
                2'd0: exp_rd = m_d0;
                default: exp_rd = '0;
            endcase
            chk("R4/R5", "lvl5_req", 64'(lvl5_req), 64'(m_busy));
            chk("R4/R5", "vec_status", 64'(vec_status), m_busy ? 64'h20 : 64'h0);
            chk("R4/R5", "hard_req", 64'(hard_req), 64'(m_busy));
            chk("R8", "trap_type", 64'(trap_type), m_busy ? 64'h60 : 64'h0);
            chk("R3", "data_w0", data_w0, m_d0);
            chk("R3", "data_w1", data_w1, 64'h0);
            chk("R3", "data_w2", data_w2, 64'h0);
            chk("R10", "rd_data", rd_data, exp_rd);
        end
    end

    task automatic drive(input logic [15:0] l, input logic [1:0] s, input int n);
        @(negedge clk);
        irq_lines = l;
        rd_sel    = s;
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic summary_and_end;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary_and_end();
    end

    initial begin
        repeat (2) @(posedge clk);
        cmp_en = 1;
        repeat (2) @(posedge clk);
        // R1: reset state
        @(negedge clk); #2;
        chk("R1", "reset hard_req", 64'(hard_req), 64'h0);
        chk("R1", "reset data_w0", data_w0, 64'h0);
        chk("R1", "reset trap_type", 64'(trap_type), 64'h0);
        rst = 1'b0;

        // R6: unmapped lines only
        drive(16'hEF2D, 2'd0, 6);
        chk("R6", "unmapped hard_req", 64'(hard_req), 64'h0);
        drive(16'h0000, 2'd0, 2);

        // R2: each mapped line alone
        drive(16'h0002, 2'd0, 3);
        chk("R2", "line1 word0", rd_data, 64'h7e9);
        drive(16'h0000, 2'd0, 2);
        drive(16'h0040, 2'd1, 3);
        chk("R2", "line6 word0", data_w0, 64'h7e7);
        chk("R10", "sel1 read", rd_data, 64'h0);
        drive(16'h0000, 2'd3, 2);
        chk("R10", "sel3 read", rd_data, 64'h0);
        chk("R5", "data held after drop", data_w0, 64'h7e7);

        // R7: lowest first among 4,7,12
        drive(16'h1090, 2'd0, 3);
        chk("R7", "lowest line4", data_w0, 64'h7eb);
        chk("R8", "trap while pending", 64'(trap_type), 64'h60);
        // served line drops: idle one cycle, then line 7
        @(negedge clk); irq_lines = 16'h1080;
        @(negedge clk); #2;
        chk("R7", "idle gap", 64'(hard_req), 64'h0);
        @(negedge clk); #2;
        chk("R7", "next line7", data_w0, 64'h7e2);
        // R9: lower line 1 rises while 7 is held
        drive(16'h1082, 2'd0, 4);
        chk("R9", "no preempt", data_w0, 64'h7e2);
        drive(16'h1002, 2'd0, 3);
        chk("R7", "then line1", data_w0, 64'h7e9);
        drive(16'h1000, 2'd2, 3);
        chk("R2", "line12 word0", data_w0, 64'h7ea);
        drive(16'h0000, 2'd0, 3);
        chk("R5", "released", 64'(lvl5_req), 64'h0);
        chk("R8", "trap idle", 64'(trap_type), 64'h0);

        // R4: re-assert after release redispatches
        drive(16'h0010, 2'd0, 2);
        chk("R4", "redispatch status", 64'(vec_status), 64'h20);
        drive(16'hFFFF, 2'd0, 3);
        chk("R9", "all high keeps line4", data_w0, 64'h7eb);
        drive(16'h0000, 2'd0, 3);

        // reset mid-service
        drive(16'h0080, 2'd0, 3);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); #2;
        chk("R1", "reset clears word0", data_w0, 64'h0);
        chk("R1", "reset clears req", 64'(hard_req), 64'h0);
        rst = 1'b0;
        drive(16'h0000, 2'd0, 3);

        summary_and_end();
    end

endmodule